// File: doc/BRIEF.md
# Programmable Reference Divider with Pulse Output

This block divides an oscillator clock by a programmable ratio. A down counter runs on the oscillator's rising edges. Each time it completes a period, it emits one short high pulse. That pulse feeds an on-chip phase detector directly. A gated copy of the pulse drives an external test pin.

A new ratio is captured with a one-cycle load strobe and takes effect only at the next terminal count, so a period in progress always finishes. A ratio of 1 selects a bypass mode, in which the oscillator itself appears on both outputs. Ratios that cannot be counted (0, 2, 3 and 4) are replaced by the smallest legal ratio, and a flag reports the substitution. The counter has no minimum rate, so the oscillator may run arbitrarily slowly or stop.

Top module: `ref_divider`

## Requirements
- R1: While reset is asserted and after its release, `pd_pulse_o`, `pin_o` and `ratio_err_o` are low. With no load, the divider counts by 5, so the first pulse starts on the 5th rising edge after reset is released.
- R2: With ratio N (5 to 32767) in effect, pulses start on rising edges exactly N edges apart.
- R3: Each pulse in divide mode begins at a rising edge and ends at the falling edge 4 cycles later, so it stays high for 4.5 oscillator cycles (9 half cycles).
- R4: A ratio loaded mid-period becomes effective at the next terminal count. The pulse that completes the current period is not moved.
- R5: A ratio of 1 selects bypass. From the terminal count that applies it, `pd_pulse_o` equals the oscillator level. Loading a ratio of 5 or more returns the block to divide mode at the next rising edge.
- R6: Loading 0, 2, 3 or 4 makes the divider count by 5 and sets `ratio_err_o` at the load edge. A later load of a legal value clears it at that load edge.
- R7: `pin_o` equals `pd_pulse_o` while `pin_en_i` is 1 and is held low while it is 0. `pd_pulse_o` runs unchanged in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator input; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ratio_i | input | 15 | Divide ratio to load |
| load_i | input | 1 | Captures `ratio_i` on a rising edge |
| pin_en_i | input | 1 | Enables the test pin output |
| pd_pulse_o | output | 1 | Divided pulse to the phase detector |
| pin_o | output | 1 | Gated copy of the pulse for the test pin |
| ratio_err_o | output | 1 | Last loaded ratio was illegal and was replaced by 5 |

## Verification
A pulse rises in the same rising edge at which the count reaches its terminal value. It falls 4.5 cycles later on a falling edge. For that reason the bench samples the outputs 2.5 ns after every edge of either polarity and measures pulse starts and widths in half cycles.

A reference count, stepped on the same rising edges, predicts the cycle of each terminal count and pushes that cycle into a queue. The monitor compares each observed pulse against that prediction when the pulse ends. A load is seen one edge after it is driven, and the error flag is checked half a cycle after that edge.

Monitoring pauses across each switch into or out of bypass. While bypass is active, the pulse output is compared against the oscillator level at every half-cycle sample.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef enum logic {
      DIV_MODE_COUNT = 1'b0,
      DIV_MODE_PASS  = 1'b1
   } div_mode_e;

   // A ratio is unusable when it is zero or sits between bypass and the minimum.
   function automatic logic ratio_illegal(input int value, input int min_legal);
      return (value == 0) || ((value > 1) && (value < min_legal));
   endfunction

endpackage

// File: rtl/refdiv_ratio_ctl.sv
module refdiv_ratio_ctl
   import refdiv_pkg::*;
#(
   parameter int RATIO_W   = 15,
   parameter int MIN_RATIO = 5,
   parameter int RST_RATIO = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               term_i,
   output logic [RATIO_W-1:0] next_ratio_o,
   output div_mode_e          mode_o,
   output logic               err_o
);
   localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] RST_V = RATIO_W'(RST_RATIO);
   localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

   logic               illegal;
   logic [RATIO_W-1:0] clean_ratio;
   logic [RATIO_W-1:0] pend_q;
   div_mode_e          mode_q;
   logic               err_q;

   assign illegal     = ratio_illegal(32'(ratio_i), MIN_RATIO);
   assign clean_ratio = illegal ? MIN_V : ratio_i;

   // The pending ratio holds the value for the period after the current one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= RST_V;
         err_q  <= 1'b0;
      end else if (load_i) begin
         pend_q <= clean_ratio;
         err_q  <= illegal;
      end
   end

   // The mode changes only at a terminal count, together with the reload.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= (RST_V == ONE_V) ? DIV_MODE_PASS : DIV_MODE_COUNT;
      end else if (term_i) begin
         mode_q <= (pend_q == ONE_V) ? DIV_MODE_PASS : DIV_MODE_COUNT;
      end
   end

   assign next_ratio_o = pend_q;
   assign mode_o       = mode_q;
   assign err_o        = err_q;

   assert_illegal_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && illegal) |=> (err_o && next_ratio_o == MIN_V));

   assert_legal_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !illegal) |=> (!err_o && next_ratio_o == $past(ratio_i)));

   assert_mode_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !term_i |=> $stable(mode_o));

   assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(next_ratio_o));

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int RATIO_W   = 15,
   parameter int RST_RATIO = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] reload_i,
   output logic               term_o
);
   localparam logic [RATIO_W-1:0] RST_V = RATIO_W'(RST_RATIO);
   localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

   logic [RATIO_W-1:0] cnt_q;

   // Count 1 is terminal. Reloading N makes the next terminal come N edges later.
   assign term_o = (cnt_q == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_V;
      end else if (term_o) begin
         cnt_q <= reload_i;
      end else begin
         cnt_q <= cnt_q - ONE_V;
      end
   end

   assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !term_o |=> (cnt_q == $past(cnt_q) - ONE_V));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |=> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/refdiv_pulse_shaper.sv
module refdiv_pulse_shaper #(
   parameter int PULSE_CYC   = 4,
   parameter bit HALF_EXTEND = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic bypass_i,
   output logic pulse_o
);
   localparam int PW_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [PW_W-1:0] PW_LAST = PW_W'(PULSE_CYC - 1);

   logic            rise_q;
   logic [PW_W-1:0] pw_q;
   logic            shaped;

   // Rising-edge part: high for PULSE_CYC whole cycles from the start edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= 1'b0;
         pw_q   <= '0;
      end else if (start_i) begin
         rise_q <= 1'b1;
         pw_q   <= PW_LAST;
      end else if (pw_q != '0) begin
         pw_q   <= pw_q - 1'b1;
      end else begin
         rise_q <= 1'b0;
      end
   end

   generate
      if (HALF_EXTEND) begin : g_half
         logic fall_q;
         // The falling-edge copy keeps the pulse high for an extra half cycle.
         // It overlaps the rising-edge part, so the OR has no gap.
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q <= 1'b0;
            else        fall_q <= rise_q;
         end
         assign shaped = rise_q | fall_q;
      end else begin : g_whole
         assign shaped = rise_q;
      end
   endgenerate

   assign pulse_o = bypass_i ? clk : shaped;

   assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (rise_q && pw_q == PW_LAST));

   assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_q && pw_q == '0 && !start_i) |=> !rise_q);

endmodule

// File: rtl/ref_divider.sv
module ref_divider
   import refdiv_pkg::*;
#(
   parameter int RATIO_W     = 15,
   parameter int MIN_RATIO   = 5,
   parameter int RST_RATIO   = 5,
   parameter int PULSE_CYC   = 4,
   parameter bit HALF_EXTEND = 1'b1
) (
   input  logic               osc_clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               load_i,
   input  logic               pin_en_i,
   output logic               pd_pulse_o,
   output logic               pin_o,
   output logic               ratio_err_o
);
   localparam int MAX_RATIO = (1 << RATIO_W) - 1;

   generate
      if (RATIO_W < 4 || RATIO_W > 30) begin : g_bad_width
         $error("ref_divider: RATIO_W out of range");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("ref_divider: PULSE_CYC must be at least 1");
      end
      if (MIN_RATIO < PULSE_CYC + 1 || MIN_RATIO > MAX_RATIO) begin : g_bad_min
         $error("ref_divider: MIN_RATIO must exceed the pulse length");
      end
      if (RST_RATIO != 1 && (RST_RATIO < MIN_RATIO || RST_RATIO > MAX_RATIO)) begin : g_bad_rst
         $error("ref_divider: RST_RATIO is not a legal ratio");
      end
   endgenerate

   logic [RATIO_W-1:0] next_ratio;
   div_mode_e          mode;
   logic               term;
   logic               start;
   logic               pulse;

   refdiv_ratio_ctl #(
      .RATIO_W   (RATIO_W),
      .MIN_RATIO (MIN_RATIO),
      .RST_RATIO (RST_RATIO)
   ) u_ctl (
      .clk          (osc_clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .ratio_i      (ratio_i),
      .term_i       (term),
      .next_ratio_o (next_ratio),
      .mode_o       (mode),
      .err_o        (ratio_err_o)
   );

   refdiv_counter #(
      .RATIO_W   (RATIO_W),
      .RST_RATIO (RST_RATIO)
   ) u_cnt (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .reload_i (next_ratio),
      .term_o   (term)
   );

   // A pulse is started only by a terminal count that ends a counted period.
   assign start = term && (mode == DIV_MODE_COUNT);

   refdiv_pulse_shaper #(
      .PULSE_CYC   (PULSE_CYC),
      .HALF_EXTEND (HALF_EXTEND)
   ) u_shape (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .bypass_i (mode == DIV_MODE_PASS),
      .pulse_o  (pulse)
   );

   assign pd_pulse_o = pulse;
   assign pin_o      = pin_en_i & pulse;

endmodule

// File: tb/sim_ref_divider.sv
`timescale 1ns/1ps
module sim_ref_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        pin_en = 1'b1;
   logic [14:0] ratio = '0;
   logic        pd, pin, err;

   always #5 clk = ~clk;

   ref_divider u0 (
      .osc_clk     (osc_clk_w),
      .rst_n       (rst_n),
      .ratio_i     (ratio),
      .load_i      (load),
      .pin_en_i    (pin_en),
      .pd_pulse_o  (pd),
      .pin_o       (pin),
      .ratio_err_o (err)
   );
   logic osc_clk_w;
   assign osc_clk_w = clk;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R1";

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference count from the requirements; pushes expected pulse start cycles.
   int exp_q[$];
   int m_cyc, m_cnt, m_pend;
   bit m_byp;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cyc = 0; m_cnt = 5; m_pend = 5; m_byp = 0;
      end else begin
         m_cyc++;
         if (m_cnt == 1) begin
            if (!m_byp) exp_q.push_back(m_cyc);
            m_byp = (m_pend == 1);
            m_cnt = m_pend;
         end else begin
            m_cnt--;
         end
         if (load)
            m_pend = (ratio == 0 || (ratio > 1 && ratio < 5)) ? 5 : int'(ratio);
      end
   end

   // Monitor: samples 2.5 ns after every edge and scores each finished pulse.
   bit mon_on = 0, byp_chk = 0, prev = 0;
   int st = 0, wd = 0;

   task automatic sample(input bit hi);
      if (pin_en) chk("R7", int'(pin), int'(pd), "pin follows pulse when enabled");
      else        chk("R7", int'(pin), 0, "pin held low when disabled");
      if (byp_chk) chk("R5", int'(pd), int'(hi), "bypass output equals oscillator");
      if (mon_on) begin
         if (pd && !prev) begin
            st = m_cyc; wd = 1;
            chk("R3", int'(hi), 1, "pulse begins after a rising edge");
         end else if (pd && prev) begin
            wd++;
         end else if (!pd && prev) begin
            if (exp_q.size() == 0) begin
               chk(cur_req, st, -1, "unexpected pulse start cycle");
            end else begin
               chk(cur_req, st, exp_q.pop_front(), "pulse start cycle");
               chk("R3", wd, 9, "pulse width in half cycles");
            end
         end
         prev = pd;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk); #2.5; if (!done) sample(1'b1);
         @(negedge clk); #2.5; if (!done) sample(1'b0);
      end
   end

   task automatic load_ratio(input int v);
      @(negedge clk);
      ratio = 15'(v); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic phase_end(input string req);
      chk(req, int'(exp_q.size() <= 1), 1, "no pulse missing");
   endtask

   task automatic finish_up();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1_900_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_up();
   end

   initial begin
      // R1: reset state
      #12;
      chk("R1", int'(pd), 0, "pulse low in reset");
      chk("R1", int'(pin), 0, "pin low in reset");
      chk("R1", int'(err), 0, "error flag low in reset");
      mon_on = 1;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1", int'(err), 0, "error flag low after reset");
      cur_req = "R1";
      wait_cyc(12);
      cur_req = "R2";
      wait_cyc(20);
      phase_end("R2");

      // R4: load mid-period, current period must finish at the old ratio
      cur_req = "R4";
      @(posedge clk); #1; wait (pd == 1'b1);
      load_ratio(7);
      wait_cyc(40);
      load_ratio(13);
      wait_cyc(60);
      phase_end("R4");

      // R2: several ratios, including the largest
      cur_req = "R2";
      load_ratio(100);
      wait_cyc(420);
      phase_end("R2");
      load_ratio(32767);
      wait_cyc(100 + 2 * 32767 + 20);
      phase_end("R2");
      load_ratio(5);
      wait_cyc(32767 + 40);
      phase_end("R2");

      // R6: illegal values count by 5 and raise the flag
      cur_req = "R6";
      load_ratio(3);
      #3; chk("R6", int'(err), 1, "flag after loading 3");
      wait_cyc(30);
      load_ratio(0);
      #3; chk("R6", int'(err), 1, "flag after loading 0");
      wait_cyc(30);
      load_ratio(6);
      #3; chk("R6", int'(err), 0, "flag cleared by legal load");
      wait_cyc(30);
      phase_end("R6");

      // R7: test pin disabled, phase detector pulse continues
      cur_req = "R7";
      @(negedge clk); pin_en = 1'b0;
      wait_cyc(40);
      @(negedge clk); pin_en = 1'b1;
      wait_cyc(10);
      phase_end("R7");

      // R5: bypass and return
      cur_req = "R5";
      mon_on = 0;
      load_ratio(1);
      wait (m_byp == 1'b1);
      @(negedge clk);
      exp_q.delete(); prev = 0;
      byp_chk = 1;
      wait_cyc(20);
      byp_chk = 0;
      load_ratio(6);
      wait (m_byp == 1'b0);
      @(negedge clk);
      #1; chk("R5", int'(pd), 0, "divide mode output low after bypass");
      prev = 0; mon_on = 1;
      cur_req = "R5";
      wait_cyc(40);
      phase_end("R5");

      finish_up();
   end
endmodule